// File: doc/BRIEF.md
# Thermal Monitor Register and Interrupt Unit

This block sits between an on-die temperature sensor and a processor bus. It takes an 8-bit temperature code with a valid strobe and keeps the last code it accepted. It compares every accepted code against a set of programmable upward thresholds and downward thresholds. Each threshold crossing sets a sticky status bit. The status bits are ANDed with an enable mask and ORed together to drive a single interrupt line.

Software sees everything through a flat 32-bit register bus. The bus has an address, a write strobe, write data and a combinational read-data return. A control word switches the sensing core on and off with a two-bit code and also holds the analog tuning fields. A trim word can be refreshed on request from a fuse-value input. The analog sensor, the fuse array and any code-to-degree conversion lie outside this block.

Top module: `thermal_mon_regs`

## Requirements
- R1: After reset the control register reads 0x0000_0002, all other registers read 0, and `irq_o` is low.
- R2: The control register at 0x20 stores and returns all 32 bits. The sensing core is on exactly when bits [1:0] equal 3; any other value, such as 2, switches it off. The analog tuning fields are gain from bit 8, mode from bit 13, mux select from bit 20 and reference from bit 24.
- R3: Register 0x40 returns, in bits [7:0], the most recent code accepted from the sensor. A code is accepted when `sens_valid_i` is high and the core is on.
- R4: Register 0x50 holds the upward thresholds and register 0x54 holds the downward thresholds. In each, level 0 is in bits [7:0], level 1 in [15:8] and level 2 in [23:16]. Bits [31:24] read 0.
- R5: An accepted code that is at or above the upward threshold of level i, where the previously accepted code was below it, sets status bit 4*i at 0x74. The previous code is 0 after reset.
- R6: An accepted code that is below a nonzero downward threshold of level i, where the previously accepted code was at or above it, sets status bit 16+4*i. A zero downward threshold never fires.
- R7: Writing ones to register 0x78 clears the matching status bits. A clear and a new event on the same bit in the same cycle leave the bit set. Register 0x78 reads 0.
- R8: Register 0x70 keeps only bits 0, 4, 8, 12, 16, 20 and 24. `irq_o` is high exactly when some status bit and its enable bit at the same position are both set.
- R9: While the core is off, sensor codes are ignored: the current code and the status bits do not change.
- R10: Bit 0 of register 0x28 is 1 when the core is on and at least one code has been accepted since the core was last switched on. All other bits of 0x28 read 0.
- R11: The trim register at 0x00 is read-only. Writing a word with bit 0 set to register 0x14 copies `fuse_word_i` into it, with the first trim value in bits [7:0] and the second in bits [15:8]. Register 0x14 reads 0.
- R12: Reads from unmapped addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W (8) | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, same cycle |
| sens_valid_i | input | 1 | Sensor code strobe |
| sens_code_i | input | CODE_W (8) | Sensor temperature code |
| fuse_word_i | input | FUSE_W (16) | Fuse trim value for reload |
| irq_o | output | 1 | Interrupt, level |

## Verification
A reference model compares the read data and the interrupt on every clock, first under directed traffic and then under random traffic.

The directed code ramp climbs 10, 40, 70, 100, repeats 100 and then drops to 20. This separates the upward edges of each level, shows that a repeated high code does not fire again, and shows that one large drop fires all three downward levels at once. A clear issued in the same cycle as a new crossing tells a set-wins design apart from a clear-wins one. Samples sent while the core is off, and trim writes without bit 0, check that ignored inputs leave no trace. The random phase mixes control writes that toggle the core with random thresholds and codes.

// File: rtl/thm_pkg.sv
package thm_pkg;
   localparam int unsigned OFS_TRIM   = 32'h00;
   localparam int unsigned OFS_RELOAD = 32'h14;
   localparam int unsigned OFS_CTRL   = 32'h20;
   localparam int unsigned OFS_STATE  = 32'h28;
   localparam int unsigned OFS_CODE   = 32'h40;
   localparam int unsigned OFS_RISE   = 32'h50;
   localparam int unsigned OFS_FALL   = 32'h54;
   localparam int unsigned OFS_IEN    = 32'h70;
   localparam int unsigned OFS_ISTAT  = 32'h74;
   localparam int unsigned OFS_ICLR   = 32'h78;

   localparam logic [1:0] CORE_ON  = 2'b11;
   localparam logic [1:0] CORE_OFF = 2'b10;

   localparam int unsigned LVL_STRIDE = 4;
   localparam int unsigned FALL_BASE  = 16;
   localparam int unsigned THR_STRIDE = 8;
   localparam int unsigned MAX_LEVELS = 4;

   // one bit per level, spaced LVL_STRIDE apart, starting at base
   function automatic logic [31:0] lvl_mask(int unsigned base, int unsigned n);
      logic [31:0] m;
      m = '0;
      for (int unsigned i = 0; i < n; i++) m[base + i * LVL_STRIDE] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/thm_level_cmp.sv
module thm_level_cmp #(
   parameter int unsigned CODE_W = 8
) (
   input  logic              fire_i,
   input  logic [CODE_W-1:0] prev_i,
   input  logic [CODE_W-1:0] new_i,
   input  logic [CODE_W-1:0] rise_thr_i,
   input  logic [CODE_W-1:0] fall_thr_i,
   output logic              rise_o,
   output logic              fall_o
);
   logic new_hi_rise, prev_hi_rise, new_hi_fall, prev_hi_fall, fall_armed;

   assign new_hi_rise  = (new_i  >= rise_thr_i);
   assign prev_hi_rise = (prev_i >= rise_thr_i);
   assign new_hi_fall  = (new_i  >= fall_thr_i);
   assign prev_hi_fall = (prev_i >= fall_thr_i);
   assign fall_armed   = (fall_thr_i != '0);

   assign rise_o = fire_i & new_hi_rise & ~prev_hi_rise;
   assign fall_o = fire_i & fall_armed & ~new_hi_fall & prev_hi_fall;
endmodule

// File: rtl/thm_sticky.sv
module thm_sticky #(
   parameter int unsigned W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= (q_o & ~clr_i) | set_i;
   end
endmodule

// File: rtl/thm_sample_track.sv
module thm_sample_track #(
   parameter int unsigned CODE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              core_on_i,
   input  logic              valid_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              accept_o,
   output logic [CODE_W-1:0] code_q_o,
   output logic              seen_q_o
);
   assign accept_o = valid_i & core_on_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         code_q_o <= '0;
         seen_q_o <= 1'b0;
      end else begin
         if (accept_o) code_q_o <= code_i;
         if (!core_on_i)   seen_q_o <= 1'b0;
         else if (valid_i) seen_q_o <= 1'b1;
      end
   end
endmodule

// File: rtl/thermal_mon_regs.sv
module thermal_mon_regs
   import thm_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned CODE_W     = 8,
   parameter int unsigned FUSE_W     = 16,
   parameter int unsigned NUM_LEVELS = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   input  logic              sens_valid_i,
   input  logic [CODE_W-1:0] sens_code_i,
   input  logic [FUSE_W-1:0] fuse_word_i,
   output logic              irq_o
);
   localparam int unsigned THR_W      = THR_STRIDE * NUM_LEVELS;
   localparam logic [31:0] STAT_MASK  = lvl_mask(0, NUM_LEVELS) | lvl_mask(FALL_BASE, NUM_LEVELS);
   localparam logic [31:0] IEN_MASK   = lvl_mask(0, MAX_LEVELS) | lvl_mask(FALL_BASE, NUM_LEVELS);
   localparam logic [31:0] CTRL_RESET = {30'b0, CORE_OFF};

   // elaboration-time parameter checks
   if (NUM_LEVELS < 1 || NUM_LEVELS > MAX_LEVELS) begin : g_bad_levels
      $error("NUM_LEVELS must be 1..4");
   end
   if (CODE_W < 1 || CODE_W > THR_STRIDE) begin : g_bad_code
      $error("CODE_W must be 1..8");
   end
   if (FUSE_W < 1 || FUSE_W > 32) begin : g_bad_fuse
      $error("FUSE_W must be 1..32");
   end
   if (ADDR_W < 7 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must be 7..32");
   end

   // per-level threshold field mask
   function automatic logic [THR_W-1:0] thr_mask();
      logic [THR_W-1:0] m;
      m = '0;
      for (int unsigned i = 0; i < NUM_LEVELS; i++)
         for (int unsigned b = 0; b < CODE_W; b++) m[i * THR_STRIDE + b] = 1'b1;
      return m;
   endfunction
   localparam logic [THR_W-1:0] THR_MASK = thr_mask();

   logic [31:0]       wide_addr;
   logic [31:0]       ctrl_q;
   logic [THR_W-1:0]  rise_q;
   logic [THR_W-1:0]  fall_q;
   logic [31:0]       ien_q;
   logic [FUSE_W-1:0] trim_q;
   logic [31:0]       stat_q;
   logic [31:0]       stat_set;
   logic [31:0]       stat_clr;
   logic              core_on;
   logic              accept;
   logic [CODE_W-1:0] code_q;
   logic              seen_q;
   logic              ready;
   logic [NUM_LEVELS-1:0] rise_evt;
   logic [NUM_LEVELS-1:0] fall_evt;

   assign wide_addr = 32'(bus_addr_i);
   assign core_on   = (ctrl_q[1:0] == CORE_ON);
   assign ready     = core_on & seen_q;

   // programmable registers
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= CTRL_RESET;
         rise_q <= '0;
         fall_q <= '0;
         ien_q  <= '0;
         trim_q <= '0;
      end else if (bus_we_i) begin
         case (wide_addr)
            OFS_CTRL:   ctrl_q <= bus_wdata_i;
            OFS_RISE:   rise_q <= bus_wdata_i[THR_W-1:0] & THR_MASK;
            OFS_FALL:   fall_q <= bus_wdata_i[THR_W-1:0] & THR_MASK;
            OFS_IEN:    ien_q  <= bus_wdata_i & IEN_MASK;
            OFS_RELOAD: if (bus_wdata_i[0]) trim_q <= fuse_word_i;
            default: ;
         endcase
      end
   end

   thm_sample_track #(.CODE_W(CODE_W)) u_track (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .core_on_i (core_on),
      .valid_i   (sens_valid_i),
      .code_i    (sens_code_i),
      .accept_o  (accept),
      .code_q_o  (code_q),
      .seen_q_o  (seen_q)
   );

   for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
      thm_level_cmp #(.CODE_W(CODE_W)) u_cmp (
         .fire_i     (accept),
         .prev_i     (code_q),
         .new_i      (sens_code_i),
         .rise_thr_i (rise_q[g * THR_STRIDE +: CODE_W]),
         .fall_thr_i (fall_q[g * THR_STRIDE +: CODE_W]),
         .rise_o     (rise_evt[g]),
         .fall_o     (fall_evt[g])
      );
   end

   always_comb begin
      stat_set = '0;
      for (int unsigned i = 0; i < NUM_LEVELS; i++) begin
         stat_set[i * LVL_STRIDE]             = rise_evt[i];
         stat_set[FALL_BASE + i * LVL_STRIDE] = fall_evt[i];
      end
   end

   assign stat_clr = (bus_we_i && wide_addr == OFS_ICLR) ? (bus_wdata_i & STAT_MASK) : '0;

   thm_sticky #(.W(32)) u_stat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (stat_set),
      .clr_i  (stat_clr),
      .q_o    (stat_q)
   );

   assign irq_o = |(stat_q & ien_q);

   // read return
   always_comb begin
      case (wide_addr)
         OFS_TRIM:  bus_rdata_o = 32'(trim_q);
         OFS_CTRL:  bus_rdata_o = ctrl_q;
         OFS_STATE: bus_rdata_o = {31'b0, ready};
         OFS_CODE:  bus_rdata_o = 32'(code_q);
         OFS_RISE:  bus_rdata_o = 32'(rise_q);
         OFS_FALL:  bus_rdata_o = 32'(fall_q);
         OFS_IEN:   bus_rdata_o = ien_q;
         OFS_ISTAT: bus_rdata_o = stat_q;
         default:   bus_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/thm_mon_chk.sv
module thm_mon_chk
   import thm_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CODE_W = 8,
   parameter int unsigned FUSE_W = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              bus_we_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic [31:0]       bus_wdata_i,
   input logic              sens_valid_i,
   input logic              irq_o,
   input logic              core_on,
   input logic [CODE_W-1:0] code_q,
   input logic [31:0]       stat_q,
   input logic [FUSE_W-1:0] trim_q,
   input logic              ready
);
   logic        clr_hit;
   logic [31:0] clr_vec;
   logic        reload_hit;

   assign clr_hit    = bus_we_i && (32'(bus_addr_i) == OFS_ICLR);
   assign clr_vec    = clr_hit ? bus_wdata_i : '0;
   assign reload_hit = bus_we_i && (32'(bus_addr_i) == OFS_RELOAD) && bus_wdata_i[0];

   p_code_frozen_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !core_on |=> $stable(code_q));

   p_stat_frozen_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!core_on && !clr_hit) |=> $stable(stat_q));

   p_no_silent_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> ((($past(stat_q) & ~stat_q) & ~$past(clr_vec)) == 32'b0));

   p_irq_needs_stat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (stat_q != 32'b0));

   p_ready_from_sample_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ready) |-> $past(sens_valid_i));

   p_trim_only_reload_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !reload_hit |=> $stable(trim_q));
endmodule

bind thermal_mon_regs thm_mon_chk #(
   .ADDR_W (ADDR_W),
   .CODE_W (CODE_W),
   .FUSE_W (FUSE_W)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .bus_we_i     (bus_we_i),
   .bus_addr_i   (bus_addr_i),
   .bus_wdata_i  (bus_wdata_i),
   .sens_valid_i (sens_valid_i),
   .irq_o        (irq_o),
   .core_on      (core_on),
   .code_q       (code_q),
   .stat_q       (stat_q),
   .trim_q       (trim_q),
   .ready        (ready)
);

// File: tb/thermal_mon_regs_tb_top.sv
module thermal_mon_regs_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        we;
   logic [7:0]  addr;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic        valid;
   logic [7:0]  code;
   logic [15:0] fuse;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   thermal_mon_regs dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .bus_we_i     (we),
      .bus_addr_i   (addr),
      .bus_wdata_i  (wdata),
      .bus_rdata_o  (rdata),
      .sens_valid_i (valid),
      .sens_code_i  (code),
      .fuse_word_i  (fuse),
      .irq_o        (irq)
   );

   // ---------------- reference model ----------------
   logic [31:0] m_ctrl, m_ien, m_stat, ev, clrv;
   logic [23:0] m_rise, m_fall;
   logic [7:0]  m_code, rt, ft;
   logic [15:0] m_trim;
   logic        m_seen, m_on;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl = 32'h2; m_ien = 0; m_stat = 0; m_rise = 0; m_fall = 0;
         m_code = 0; m_trim = 0; m_seen = 0;
      end else begin
         m_on = (m_ctrl[1:0] == 2'd3);
         ev = 0;
         if (m_on && valid) begin
            for (int i = 0; i < 3; i++) begin
               rt = m_rise[8*i +: 8];
               ft = m_fall[8*i +: 8];
               if (code >= rt && m_code < rt) ev[4*i] = 1'b1;
               if (ft != 0 && code < ft && m_code >= ft) ev[16+4*i] = 1'b1;
            end
         end
         clrv = (we && addr == 8'h78) ? wdata : 32'h0;
         m_stat = (m_stat & ~clrv) | ev;
         if (m_on && valid) m_code = code;
         if (!m_on) m_seen = 1'b0;
         else if (valid) m_seen = 1'b1;
         if (we) begin
            case (addr)
               8'h20: m_ctrl = wdata;
               8'h50: m_rise = wdata[23:0];
               8'h54: m_fall = wdata[23:0];
               8'h70: m_ien  = wdata & 32'h0111_1111;
               8'h14: if (wdata[0]) m_trim = fuse;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] m_read(logic [7:0] a);
      case (a)
         8'h00: return {16'h0, m_trim};
         8'h20: return m_ctrl;
         8'h28: return {31'h0, (m_ctrl[1:0] == 2'd3) && m_seen};
         8'h40: return {24'h0, m_code};
         8'h50: return {8'h0, m_rise};
         8'h54: return {8'h0, m_fall};
         8'h70: return m_ien;
         8'h74: return m_stat;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(logic [7:0] a);
      case (a)
         8'h00, 8'h14: return "R11";
         8'h20:        return "R2";
         8'h28:        return "R10";
         8'h40:        return "R3/R9";
         8'h50, 8'h54: return "R4";
         8'h70:        return "R8";
         8'h74:        return "R5/R6/R7";
         8'h78:        return "R7";
         default:      return "R12";
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         chk({tag_of(addr), " read"}, rdata, m_read(addr));
         chk("R8 irq", {31'h0, irq}, {31'h0, |(m_stat & m_ien)});
      end
   end

   task automatic step(bit w, logic [7:0] a, logic [31:0] d, bit v, logic [7:0] c);
      @(posedge clk);
      #1;
      we = w; addr = a; wdata = d; valid = v; code = c;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
      step(0, a, 32'h0, 0, 8'h0);
      @(negedge clk);
      chk(tag, rdata, exp);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   initial begin
      rst_n = 0; we = 0; addr = 0; wdata = 0; valid = 0; code = 0; fuse = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      rd(8'h20, 32'h2, "R1 control reset");
      rd(8'h74, 32'h0, "R1 status reset");
      rd(8'h40, 32'h0, "R1 code reset");
      rd(8'h00, 32'h0, "R1 trim reset");
      chk("R1 irq reset", {31'h0, irq}, 32'h0);

      step(0, 8'h40, 0, 1, 8'd50);
      rd(8'h40, 32'h0, "R9 code ignored while off");
      rd(8'h28, 32'h0, "R10 not ready while off");

      step(1, 8'h20, 32'h0601_1003, 0, 0);
      rd(8'h20, 32'h0601_1003, "R2 control readback");
      step(1, 8'h50, 32'hFF60_4020, 0, 0);
      rd(8'h50, 32'h0060_4020, "R4 rise layout");
      step(1, 8'h54, 32'h0050_3018, 0, 0);
      rd(8'h54, 32'h0050_3018, "R4 fall layout");
      step(1, 8'h70, 32'hFFFF_FFFF, 0, 0);
      rd(8'h70, 32'h0111_1111, "R8 enable mask");
      step(1, 8'h70, 32'h0111_0111, 0, 0);
      rd(8'h28, 32'h0, "R10 on but no sample");

      step(0, 8'h40, 0, 1, 8'd10);
      rd(8'h40, 32'd10, "R3 current code");
      rd(8'h28, 32'h1, "R10 ready");
      step(0, 8'h74, 0, 1, 8'd40);
      rd(8'h74, 32'h1, "R5 level0 rise");
      chk("R8 irq on", {31'h0, irq}, 32'h1);
      step(0, 8'h74, 0, 1, 8'd70);
      rd(8'h74, 32'h11, "R5 level1 rise");
      step(0, 8'h74, 0, 1, 8'd100);
      rd(8'h74, 32'h111, "R5 level2 rise");
      step(0, 8'h74, 0, 1, 8'd100);
      rd(8'h74, 32'h111, "R5 no retrigger");
      step(0, 8'h74, 0, 1, 8'd20);
      rd(8'h74, 32'h0111_0111, "R6 all levels fall");

      step(1, 8'h78, 32'h0111_0111, 0, 0);
      rd(8'h74, 32'h0, "R7 cleared");
      rd(8'h78, 32'h0, "R7 clear reads zero");
      chk("R7 irq low after clear", {31'h0, irq}, 32'h0);
      step(1, 8'h78, 32'h1, 1, 8'd50);
      rd(8'h74, 32'h1, "R7 event beats clear");

      step(1, 8'h70, 32'h0, 0, 0);
      rd(8'h74, 32'h1, "R8 status kept");
      chk("R8 irq masked", {31'h0, irq}, 32'h0);
      step(1, 8'h70, 32'h1, 0, 0);
      rd(8'h70, 32'h1, "R8 enable bit0");
      chk("R8 irq unmasked", {31'h0, irq}, 32'h1);

      step(1, 8'h20, 32'h2, 0, 0);
      rd(8'h28, 32'h0, "R10 ready drops when off");
      step(0, 8'h40, 0, 1, 8'd5);
      rd(8'h40, 32'd50, "R9 code held");
      rd(8'h74, 32'h1, "R9 status held");

      fuse = 16'hA53C;
      step(1, 8'h00, 32'hFFFF_FFFF, 0, 0);
      rd(8'h00, 32'h0, "R11 trim read-only");
      step(1, 8'h14, 32'h0, 0, 0);
      rd(8'h00, 32'h0, "R11 no reload without bit0");
      step(1, 8'h14, 32'h1, 0, 0);
      rd(8'h00, 32'h0000_A53C, "R11 reload");
      rd(8'h14, 32'h0, "R11 reload reg reads zero");

      step(1, 8'h30, 32'hFFFF_FFFF, 0, 0);
      rd(8'h30, 32'h0, "R12 unmapped read");
      rd(8'h20, 32'h2, "R12 no side effect");

      for (int k = 0; k < 3000; k++) begin
         logic [7:0]  a;
         logic [31:0] d;
         case ($urandom % 12)
            0: a = 8'h00;  1: a = 8'h14;  2: a = 8'h20;  3: a = 8'h28;
            4: a = 8'h40;  5: a = 8'h50;  6: a = 8'h54;  7: a = 8'h70;
            8: a = 8'h74;  9: a = 8'h78;  10: a = 8'h30; default: a = 8'h7C;
         endcase
         d = $urandom;
         if (a == 8'h20 && ($urandom % 4) != 0) d[1:0] = 2'd3;
         step(($urandom % 3) == 0, a, d, ($urandom % 2) == 1, 8'($urandom));
         fuse = 16'($urandom);
      end

      step(0, 8'h00, 0, 0, 0);
      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R1-all: actual running expected finished");
         summary();
         $finish;
      end
   end
endmodule